// File: doc/BRIEF.md
# Inline LFSR CRC and Noise Unit

This block is a programmable linear-feedback shift register that sits on the data path of one channel of a multi-channel data mover. Every byte that the selected channel carries can be folded into the register eight bits at a time, most significant bit first. The result is a running CRC over the stream. The same register also works as a pseudorandom source when the channel keeps feeding it a constant. The generator polynomial is a tap mask. The register length can be set anywhere from 1 to 16 bits. Both can be changed while the unit runs, and a seed can be loaded at any time.

Bytes from every channel pass through the unit. Only bytes tagged with the attached channel number, and only while the unit is enabled, update the register. In append mode an accepted byte is consumed: the word written out in its place is the register value after the update. Otherwise the byte leaves unchanged, zero-extended to the output word. The output is one clock behind the input strobe.

Top module: `lfsr_stream_crc`

## Requirements
- R1: While `rst` is high at a clock edge, `crc_value`, `wr_data` and `wr_valid` all become zero.
- R2: The effective length L is `cfg_len` when it lies in 1..16. It is 16 for a value of 0 or for any value above 16. Bits L and above read zero in `crc_value` and in any register-sourced `wr_data`. A reduced length clears those bits at the next clock edge.
- R3: An accepted byte updates the register in one clock through eight steps, taking data bit 7 first. In each step fb = reg[L-1] XOR data bit; reg becomes (reg shifted left by one, masked to L bits) XOR (fb ? `cfg_poly` masked to L bits : 0). Bit i of `cfg_poly` is the tap at position i. For example, polynomial 0x1021, length 16, seed 0xFFFF and the ASCII bytes "123456789" give 0x29B1.
- R4: A byte is accepted only when `in_valid` is 1, `cfg_en` is 1 and `in_chan` equals `cfg_chan`. Any other byte leaves the register unchanged.
- R5: A high `seed_wr` loads `seed_val` (masked to L bits) at the next edge, whether or not the unit is enabled. The load wins over an accepted byte in the same cycle.
- R6: `wr_valid` equals `in_valid` of the previous cycle, for every channel.
- R7: When an accepted byte arrives with `cfg_append` at 1, `wr_data` on the next cycle equals the new `crc_value`.
- R8: Any other valid byte (non-append, another channel, or unit disabled) appears on the next cycle as `wr_data` = {8'h00, `in_data`}.
- R9: In append mode, with polynomial 0xA010, length 16 and seed 0xFFFF, a paced stream of 0x00 bytes yields the R3 sequence of nonzero 16-bit values. No value equals the one before it, and the register holds between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Unit enable |
| cfg_append | input | 1 | 1: accepted bytes are replaced by the register value |
| cfg_chan | input | 2 | Channel number the unit is attached to |
| cfg_poly | input | 16 | Tap mask of the generator polynomial |
| cfg_len | input | 5 | Register length, 1..16 (0 or above 16 means 16) |
| seed_wr | input | 1 | Load the seed at the next edge |
| seed_val | input | 16 | Seed value |
| in_valid | input | 1 | Byte strobe |
| in_chan | input | 2 | Channel the byte belongs to |
| in_data | input | 8 | Data byte |
| crc_value | output | 16 | Current register value |
| wr_valid | output | 1 | Output word strobe |
| wr_data | output | 16 | Word to be written in place of the channel data |

## Verification
A CRC check string over the nine ASCII digits is compared against its known standard result. It separates a correct MSB-first shift, tap placement and feedback source from near misses such as LSB-first order or a wrong feedback bit. A paced run of zero bytes in append mode with the 0xA010 taps compares every output word against an independent bench model, and also checks that the register holds still in the idle gaps between bytes. Lengths of 4, 1, 0 and 20, together with a length cut on a populated register, separate correct upper-bit masking and length clamping from designs that always use 16 bits. Bytes on a foreign channel or with the unit disabled, and a seed load that coincides with an accepted byte, separate correct gating and load priority from a register that shifts too often.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;

  // Source of the outgoing data word.
  typedef enum logic {
    OUT_PASS = 1'b0,  // incoming byte, zero-extended
    OUT_REG  = 1'b1   // register value after the update
  } out_sel_e;

endpackage

// File: rtl/lfsr_len_mask.sv
// Turns the programmed length into a low-bit mask and a one-hot
// marker of the highest live bit (the feedback source).
module lfsr_len_mask #(
  parameter int unsigned REG_W = 16,
  localparam int unsigned LEN_W = $clog2(REG_W + 1)
) (
  input  logic [LEN_W-1:0] len,
  output logic [REG_W-1:0] mask,
  output logic [REG_W-1:0] top_bit
);

  logic [LEN_W-1:0] eff_len;

  // R2: zero or out-of-range lengths select the full width
  always_comb begin
    if (len == '0 || len > LEN_W'(REG_W)) eff_len = LEN_W'(REG_W);
    else                                  eff_len = len;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_mask
    assign mask[i] = (LEN_W'(i) < eff_len);
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_top
    if (i == REG_W - 1) begin : g_last
      assign top_bit[i] = mask[i];
    end else begin : g_mid
      assign top_bit[i] = mask[i] & ~mask[i+1];
    end
  end

  always_comb begin
    assert ($onehot0(top_bit)) else $error("AST_TOP_ONEHOT");  // R2
  end

endmodule

// File: rtl/lfsr_bit_step.sv
// One shift of the register for one input bit (R3).
module lfsr_bit_step #(
  parameter int unsigned REG_W = 16
) (
  input  logic [REG_W-1:0] state,
  input  logic [REG_W-1:0] poly_m,
  input  logic [REG_W-1:0] mask,
  input  logic [REG_W-1:0] top_bit,
  input  logic             din,
  output logic [REG_W-1:0] nxt
);

  logic fb;

  always_comb begin
    fb  = (|(state & top_bit)) ^ din;
    nxt = ((state << 1) & mask) ^ (poly_m & {REG_W{fb}});
  end

endmodule

// File: rtl/lfsr_byte_engine.sv
// Chains one bit step per data bit, most significant bit first.
module lfsr_byte_engine #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [REG_W-1:0]  state_in,
  input  logic [REG_W-1:0]  poly,
  input  logic [REG_W-1:0]  mask,
  input  logic [REG_W-1:0]  top_bit,
  input  logic [BYTE_W-1:0] data,
  output logic [REG_W-1:0]  state_out
);

  logic [REG_W-1:0] chain [BYTE_W+1];
  logic [REG_W-1:0] poly_m;

  assign poly_m   = poly & mask;
  assign chain[0] = state_in & mask;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_step
    lfsr_bit_step #(.REG_W(REG_W)) u_step (
      .state   (chain[k]),
      .poly_m  (poly_m),
      .mask    (mask),
      .top_bit (top_bit),
      .din     (data[BYTE_W-1-k]),
      .nxt     (chain[k+1])
    );
  end

  assign state_out = chain[BYTE_W];

endmodule

// File: rtl/lfsr_stream_crc.sv
module lfsr_stream_crc
  import lfsr_crc_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_N   = 4,
  localparam int unsigned CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int unsigned LEN_W = $clog2(REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_append,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [REG_W-1:0]  cfg_poly,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              seed_wr,
  input  logic [REG_W-1:0]  seed_val,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BYTE_W-1:0] in_data,
  output logic [REG_W-1:0]  crc_value,
  output logic              wr_valid,
  output logic [REG_W-1:0]  wr_data
);

  logic [REG_W-1:0] len_mask;
  logic [REG_W-1:0] top_bit;
  logic [REG_W-1:0] state_q;
  logic [REG_W-1:0] state_d;
  logic [REG_W-1:0] eng_out;
  logic [REG_W-1:0] pass_ext;
  logic             take;
  out_sel_e         out_sel;

  lfsr_len_mask #(.REG_W(REG_W)) u_mask (
    .len     (cfg_len),
    .mask    (len_mask),
    .top_bit (top_bit)
  );

  lfsr_byte_engine #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_eng (
    .state_in  (state_q),
    .poly      (cfg_poly),
    .mask      (len_mask),
    .top_bit   (top_bit),
    .data      (in_data),
    .state_out (eng_out)
  );

  // R4: only bytes of the attached channel, while enabled
  assign take = in_valid & cfg_en & (in_chan == cfg_chan);

  // R5: seed load has priority over a byte update
  always_comb begin
    if (seed_wr)   state_d = seed_val & len_mask;
    else if (take) state_d = eng_out;
    else           state_d = state_q & len_mask;
  end

  assign out_sel  = (take && cfg_append) ? OUT_REG : OUT_PASS;
  assign pass_ext = {{(REG_W-BYTE_W){1'b0}}, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      state_q  <= state_d;
      wr_valid <= in_valid;
      if (in_valid) begin
        wr_data <= (out_sel == OUT_REG) ? state_d : pass_ext;
      end
    end
  end

  assign crc_value = state_q;

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((crc_value & ~$past(len_mask)) == '0)) else $error("AST_UPPER_CLEAR");  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!seed_wr && !take) |=> (crc_value == ($past(crc_value) & $past(len_mask)))) else $error("AST_IDLE_HOLD");  // R4

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    seed_wr |=> (crc_value == ($past(seed_val) & $past(len_mask)))) else $error("AST_SEED_LOAD");  // R5

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_valid == $past(in_valid))) else $error("AST_VALID_LAG");  // R6

  AST_APPEND_OUT: assert property (@(posedge clk) disable iff (rst)
    (take && cfg_append) |=> (wr_data == crc_value)) else $error("AST_APPEND_OUT");  // R7

  AST_PASS_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(take && cfg_append)) |=>
      (wr_data[BYTE_W-1:0] == $past(in_data) && wr_data[REG_W-1:BYTE_W] == '0)) else $error("AST_PASS_OUT");  // R8

endmodule

// File: tb/lfsr_stream_crc_test.sv
module lfsr_stream_crc_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic        cfg_append = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [15:0] cfg_poly = '0;
  logic [4:0]  cfg_len = '0;
  logic        seed_wr = 1'b0;
  logic [15:0] seed_val = '0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_chan = '0;
  logic [7:0]  in_data = '0;
  logic [15:0] crc_value;
  logic        wr_valid;
  logic [15:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_stream_crc uut (
    .clk, .rst, .cfg_en, .cfg_append, .cfg_chan, .cfg_poly, .cfg_len,
    .seed_wr, .seed_val, .in_valid, .in_chan, .in_data,
    .crc_value, .wr_valid, .wr_data
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] len_mask_of(input int len);
    int l = (len == 0 || len > 16) ? 16 : len;
    return 16'((32'd1 << l) - 1);
  endfunction

  function automatic logic [15:0] ref_byte(input logic [15:0] s, input logic [15:0] p,
                                           input int len, input logic [7:0] b);
    int l = (len == 0 || len > 16) ? 16 : len;
    logic [15:0] m = len_mask_of(len);
    logic [15:0] r = s & m;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[l-1] ^ b[k];
      r = (r << 1) & m;
      if (fb) r = r ^ (p & m);
    end
    return r;
  endfunction

  task automatic load_seed(input logic [15:0] v);
    seed_val = v; seed_wr = 1'b1;
    @(negedge clk);
    seed_wr = 1'b0;
  endtask

  task automatic send(input logic [1:0] ch, input logic [7:0] d);
    in_chan = ch; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 crc_value", crc_value, 16'h0);
    chk("R1 wr_valid", {15'b0, wr_valid}, 16'h0);
    chk("R1 wr_data", wr_data, 16'h0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ccitt();
    cfg_en = 1; cfg_append = 0; cfg_chan = 2; cfg_poly = 16'h1021; cfg_len = 16;
    load_seed(16'hFFFF);
    chk("R5 seed load", crc_value, 16'hFFFF);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] b = 8'h31 + 8'(i);
      send(2'd2, b);
      chk("R6 wr_valid", {15'b0, wr_valid}, 16'h1);
      chk("R8 passthrough", wr_data, {8'h00, b});
    end
    chk("R3 check string", crc_value, 16'h29B1);
    @(negedge clk);
    chk("R6 wr_valid drop", {15'b0, wr_valid}, 16'h0);
  endtask

  task automatic t_gate();
    logic [15:0] keep = crc_value;
    send(2'd1, 8'hA5);
    chk("R4 other channel hold", crc_value, keep);
    chk("R8 other channel pass", wr_data, 16'h00A5);
    cfg_en = 0; cfg_append = 1;
    send(2'd2, 8'h3C);
    chk("R4 disabled hold", crc_value, keep);
    chk("R8 disabled pass", wr_data, 16'h003C);
    load_seed(16'h1234);
    chk("R5 seed while disabled", crc_value, 16'h1234);
    cfg_en = 1; cfg_append = 0;
  endtask

  task automatic t_prng();
    logic [15:0] model = 16'hFFFF;
    cfg_append = 1; cfg_poly = 16'hA010; cfg_len = 16; cfg_chan = 3;
    load_seed(16'hFFFF);
    for (int i = 0; i < 20; i++) begin
      logic [15:0] prev = model;
      model = ref_byte(model, 16'hA010, 16, 8'h00);
      send(2'd3, 8'h00);
      chk("R9 prng value", crc_value, model);
      chk("R7 append word", wr_data, model);
      checks++;
      if (model == prev || model == 16'h0) begin
        errors++;
        $display("FAIL R9 sequence actual %h expected change from %h", model, prev);
      end
      repeat (3) @(negedge clk);
      chk("R9 hold between bytes", crc_value, model);
    end
  endtask

  task automatic t_len();
    logic [15:0] model;
    cfg_append = 1; cfg_chan = 0; cfg_poly = 16'h0003; cfg_len = 4;
    load_seed(16'hFFFF);
    chk("R2 seed masked to 4 bits", crc_value, 16'h000F);
    model = 16'h000F;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = 8'h5A ^ 8'(i * 37);
      model = ref_byte(model, 16'h0003, 4, b);
      send(2'd0, b);
      chk("R3 length 4 update", crc_value, model);
      chk("R2 length 4 output word", wr_data, model);
    end
    cfg_len = 1; cfg_poly = 16'hFFFF;
    load_seed(16'h0001);
    model = ref_byte(16'h0001, 16'hFFFF, 1, 8'hB7);
    send(2'd0, 8'hB7);
    chk("R2 length 1", crc_value, model);
    cfg_len = 0; cfg_poly = 16'h8005;
    load_seed(16'hFFFF);
    chk("R2 length 0 is 16", crc_value, 16'hFFFF);
    model = ref_byte(16'hFFFF, 16'h8005, 16, 8'hC3);
    send(2'd0, 8'hC3);
    chk("R2 length 0 update", crc_value, model);
    cfg_len = 20;
    load_seed(16'hBEEF);
    chk("R2 length 20 is 16", crc_value, 16'hBEEF);
    cfg_len = 8;
    @(negedge clk);
    chk("R2 length cut clears upper", crc_value, 16'h00EF);
  endtask

  task automatic t_prio();
    cfg_len = 16; cfg_append = 1; cfg_chan = 1; cfg_poly = 16'h1021;
    load_seed(16'h0F0F);
    seed_val = 16'h4321; seed_wr = 1'b1;
    in_chan = 2'd1; in_data = 8'h99; in_valid = 1'b1;
    @(negedge clk);
    seed_wr = 1'b0; in_valid = 1'b0;
    chk("R5 seed beats byte", crc_value, 16'h4321);
    chk("R7 append word on seed cycle", wr_data, 16'h4321);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ccitt();
    t_gate();
    t_prng();
    t_len();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual 20000 cycles expected completion sooner");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule